// File: doc/BRIEF.md
# Stochastic Crossbar Update Pulse Generator

This block runs one parallel weight-update step on a crossbar of differential weight pairs. Each row has a signed probability and each column has an unsigned probability. The block turns the pair of vectors into pulse streams. In every time slot it draws a fresh random bit for each row and for each column. A row whose bit is set raises its gate line. A column whose bit is set raises its drain line. A cell is written only in a slot where its row gate and its column drain are both high. Averaged over the run, the number of updates each cell receives follows the product of its row and column probabilities, so the whole outer product is applied in one pass instead of cell by cell.

The sign of a row decides which device of the pair the update reaches. Each row has two gate outputs, one for the positive device and one for the negative device. A non-negative row drives only its positive gate, and a negative row drives only its negative gate. Both use the same potentiating drain polarity. Every row and every column has its own 8-bit maximal-length LFSR with its own nonzero seed. A line is high in a slot when the value of its LFSR is strictly below the line's 8-bit magnitude.

The request interface is a simple handshake. `start` is the valid strobe and `busy` low is the ready signal. The vectors and the length are captured in the cycle in which `start` is seen while `busy` is low. There is no back-pressure beyond that: a `start` seen while `busy` is high is dropped and is not queued, so the requester must wait for `done` or for `busy` to go low before it issues the next step.

Top module: `scpg_pulse_gen`

## Requirements
- R1: Over a run of 255 slots, a row with magnitude m (1..255) raises its gate in exactly m-1 slots, because its LFSR visits every value 1..255 once. A row with magnitude 0 raises no gate in any slot.
- R2: Over a run of 255 slots, a column with magnitude m (1..255) raises its drain in exactly m-1 slots. A column with magnitude 0 never raises its drain.
- R3: The update for a cell counts only in slots where the row gate and the column drain are both high. Because every lane has a distinct seed, a row and a column that are both at 255 coincide in exactly 253 of 255 slots. A row or a column at 0 gives zero coincidences.
- R4: Each row word is a 9-bit two's-complement value, packed with row r at bits [9r+8:9r]. A non-negative value uses its low 8 bits as the magnitude and drives only `gate_pos`. A negative value v drives only `gate_neg`, with magnitude -v. The value -256 is clipped to magnitude 255. The two gates of a row are never high together.
- R5: Each column word is 8 unsigned bits, with column c at bits [8c+7:8c]. The run length is `len_in` slots (8 bits). The value 0 selects the default of 50 slots, and the value 1 gives a single slot. One slot lasts 5 cycles, so `busy` stays high for length × 5 cycles.
- R6: Within a slot, cycle 0 is idle. The gate is high for cycles 1 to 4, and the drain is high for cycles 2 and 3 only. Each drain pulse therefore begins and ends while the gates stay steady.
- R7: A `start` that arrives while `busy` is high is ignored. It neither lengthens the run nor changes the captured vectors.
- R8: `done` is high for exactly one cycle, in the cycle after `busy` falls. While the block is idle, all gate and drain outputs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request strobe; accepted only while busy is low |
| len_in | input | 8 | Number of slots in the run; 0 selects 50 |
| row_prob | input | 288 | 32 signed 9-bit row probability words |
| col_prob | input | 256 | 32 unsigned 8-bit column probability words |
| gate_pos | output | 32 | Per-row gate pulse to the positive device |
| gate_neg | output | 32 | Per-row gate pulse to the negative device |
| drain | output | 32 | Per-column drain pulse |
| busy | output | 1 | High while a run is in progress |
| done | output | 1 | One-cycle pulse after the last slot |

## Verification
Full 255-slot runs make the pulse counts exact. An off-by-one in the comparator, such as using less-or-equal, would give m pulses instead of m-1. A lane that leaks at magnitude zero would give one pulse. Two lanes that share a seed would lose only one slot between them instead of two, giving 254 coincidences instead of 253. Mixed-sign rows and the -256 word would expose a design that sends updates to the wrong device or wraps the clipped magnitude to zero.

Length 1, length 0 (the default) and a `start` issued in the middle of a run would expose a design that counts slots wrongly or restarts on a second request. The widths of the pulse runs, and whether the gate is stable around each drain pulse, would show a drain that escapes its gate window.

// File: rtl/scpg_pkg.sv
package scpg_pkg;

  localparam int MAG_W = 8;

  // right-shifting Galois step, maximal length over the 255 nonzero states
  function automatic logic [MAG_W-1:0] lfsr_next(input logic [MAG_W-1:0] s);
    logic [MAG_W-1:0] n;
    n = s >> 1;
    if (s[0]) n = n ^ 8'hB8;
    return n;
  endfunction

  // seeds spread around the cycle; 37 is coprime to 255 so indexes below 255 stay distinct
  function automatic logic [MAG_W-1:0] lane_seed(input int idx);
    return MAG_W'(((idx * 37) % 255) + 1);
  endfunction

endpackage

// File: rtl/scpg_lane.sv
module scpg_lane
  import scpg_pkg::*;
#(
  parameter logic [MAG_W-1:0] SEED = 8'd1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [MAG_W-1:0] mag_in,
  input  logic             draw,
  output logic             bit_o
);

  logic [MAG_W-1:0] mag_q;
  logic [MAG_W-1:0] lfsr_q;
  logic             bit_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mag_q  <= '0;
      lfsr_q <= SEED;
      bit_q  <= 1'b0;
    end else begin
      if (load) mag_q <= mag_in;
      if (draw) begin
        bit_q  <= (lfsr_q < mag_q);
        lfsr_q <= lfsr_next(lfsr_q);
      end
    end
  end

  assign bit_o = bit_q;

endmodule

// File: rtl/scpg_slot_timer.sv
module scpg_slot_timer #(
  parameter int LEN_W       = 8,
  parameter int DEFAULT_LEN = 50,
  parameter int GATE_CYC    = 4,
  parameter int DRAIN_CYC   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] len_in,
  output logic             busy,
  output logic             done,
  output logic             draw,
  output logic             gate_win,
  output logic             drain_win
);

  localparam int PH_W = $clog2(GATE_CYC + 1);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(GATE_CYC);
  localparam logic [PH_W-1:0] DR_LO   = PH_W'(1 + (GATE_CYC - DRAIN_CYC) / 2);
  localparam logic [PH_W-1:0] DR_HI   = PH_W'(1 + (GATE_CYC - DRAIN_CYC) / 2 + DRAIN_CYC);

  logic [PH_W-1:0]  phase_q;
  logic [LEN_W-1:0] slot_q;
  logic [LEN_W-1:0] last_q;
  logic             busy_q;
  logic             done_q;
  logic [LEN_W-1:0] len_eff;

  assign len_eff = (len_in == '0) ? LEN_W'(DEFAULT_LEN) : len_in;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= '0;
      slot_q  <= '0;
      last_q  <= '0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start) begin
          busy_q  <= 1'b1;
          phase_q <= '0;
          slot_q  <= '0;
          last_q  <= len_eff - LEN_W'(1);
        end
      end else if (phase_q == PH_LAST) begin
        phase_q <= '0;
        if (slot_q == last_q) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          slot_q <= slot_q + LEN_W'(1);
        end
      end else begin
        phase_q <= phase_q + PH_W'(1);
      end
    end
  end

  assign busy      = busy_q;
  assign done      = done_q;
  assign draw      = busy_q && (phase_q == '0);
  assign gate_win  = busy_q && (phase_q != '0);
  assign drain_win = busy_q && (phase_q >= DR_LO) && (phase_q < DR_HI);

endmodule

// File: rtl/scpg_pulse_gen.sv
module scpg_pulse_gen
  import scpg_pkg::*;
#(
  parameter int ROWS        = 32,
  parameter int COLS        = 32,
  parameter int LEN_W       = 8,
  parameter int DEFAULT_LEN = 50,
  parameter int GATE_CYC    = 4,
  parameter int DRAIN_CYC   = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  input  logic [LEN_W-1:0]           len_in,
  input  logic [ROWS*(MAG_W+1)-1:0]  row_prob,
  input  logic [COLS*MAG_W-1:0]      col_prob,
  output logic [ROWS-1:0]            gate_pos,
  output logic [ROWS-1:0]            gate_neg,
  output logic [COLS-1:0]            drain,
  output logic                       busy,
  output logic                       done
);

  localparam int RW = MAG_W + 1;

  logic load;
  logic draw;
  logic gate_win;
  logic drain_win;

  assign load = start && !busy;

  scpg_slot_timer #(
    .LEN_W      (LEN_W),
    .DEFAULT_LEN(DEFAULT_LEN),
    .GATE_CYC   (GATE_CYC),
    .DRAIN_CYC  (DRAIN_CYC)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .len_in   (len_in),
    .busy     (busy),
    .done     (done),
    .draw     (draw),
    .gate_win (gate_win),
    .drain_win(drain_win)
  );

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    logic [RW-1:0]    word;
    logic [MAG_W-1:0] mag;
    logic [RW-1:0]    neg_word;
    logic             neg_q;
    logic             row_bit;

    assign word     = row_prob[r*RW +: RW];
    assign neg_word = (~word) + RW'(1);
    // clip: the most negative word has no 8-bit magnitude, so it saturates to full scale
    assign mag = !word[RW-1]               ? word[MAG_W-1:0] :
                 (word[MAG_W-1:0] == '0)   ? {MAG_W{1'b1}}   :
                                             neg_word[MAG_W-1:0];

    always_ff @(posedge clk) begin
      if (!rst_n)    neg_q <= 1'b0;
      else if (load) neg_q <= word[RW-1];
    end

    scpg_lane #(.SEED(lane_seed(r))) u_lane (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (load),
      .mag_in(mag),
      .draw  (draw),
      .bit_o (row_bit)
    );

    assign gate_pos[r] = gate_win && row_bit && !neg_q;
    assign gate_neg[r] = gate_win && row_bit && neg_q;
  end

  for (genvar c = 0; c < COLS; c++) begin : g_col
    logic col_bit;

    scpg_lane #(.SEED(lane_seed(ROWS + c))) u_lane (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (load),
      .mag_in(col_prob[c*MAG_W +: MAG_W]),
      .draw  (draw),
      .bit_o (col_bit)
    );

    assign drain[c] = drain_win && col_bit;
  end

endmodule

// File: rtl/scpg_pulse_gen_chk.sv
module scpg_pulse_gen_chk #(
  parameter int ROWS = 32,
  parameter int COLS = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic [ROWS-1:0] gate_pos,
  input logic [ROWS-1:0] gate_neg,
  input logic [COLS-1:0] drain,
  input logic            busy,
  input logic            done
);

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (gate_pos == '0) && (gate_neg == '0) && (drain == '0));

  // R4
  pair_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> ((gate_pos & gate_neg) == '0));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && $past(busy));

  // R6
  drain_starts_inside_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|drain) |-> $stable(gate_pos) && $stable(gate_neg));

  // R6
  drain_ends_inside_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|drain) |=> $stable(gate_pos) && $stable(gate_neg));

  // R5
  accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  // R7
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy) |=> (busy || done));

endmodule

bind scpg_pulse_gen scpg_pulse_gen_chk #(.ROWS(ROWS), .COLS(COLS)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .start   (start),
  .gate_pos(gate_pos),
  .gate_neg(gate_neg),
  .drain   (drain),
  .busy    (busy),
  .done    (done)
);

// File: tb/scpg_pulse_gen_bench.sv
module scpg_pulse_gen_bench;

  localparam int ROWS = 32;
  localparam int COLS = 32;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic                start = 1'b0;
  logic [7:0]          len_in = '0;
  logic [ROWS*9-1:0]   row_prob = '0;
  logic [COLS*8-1:0]   col_prob = '0;
  logic [ROWS-1:0]     gate_pos;
  logic [ROWS-1:0]     gate_neg;
  logic [COLS-1:0]     drain;
  logic                busy;
  logic                done;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  scpg_pulse_gen u_scpg_pulse_gen (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .len_in  (len_in),
    .row_prob(row_prob),
    .col_prob(col_prob),
    .gate_pos(gate_pos),
    .gate_neg(gate_neg),
    .drain   (drain),
    .busy    (busy),
    .done    (done)
  );

  // monitor counters
  int pos_cnt [ROWS];
  int neg_cnt [ROWS];
  int drn_cnt [COLS];
  int coin_cnt [ROWS*COLS];
  int busy_cyc, done_cyc, bad_gate_run, bad_drain_run, bad_nest, gate_run, drain_run;
  logic [ROWS-1:0]      pp, pn;
  logic [COLS-1:0]      pd;
  logic [ROWS*COLS-1:0] pc;
  logic                 mon_en = 1'b0;

  task automatic clear_counts();
    for (int i = 0; i < ROWS; i++) begin pos_cnt[i] = 0; neg_cnt[i] = 0; end
    for (int i = 0; i < COLS; i++) drn_cnt[i] = 0;
    for (int i = 0; i < ROWS*COLS; i++) coin_cnt[i] = 0;
    busy_cyc = 0; done_cyc = 0; bad_gate_run = 0; bad_drain_run = 0; bad_nest = 0;
    gate_run = 0; drain_run = 0;
  endtask

  always @(negedge clk) begin
    if (mon_en) begin
      logic [ROWS-1:0] g;
      g = gate_pos | gate_neg;
      if (busy) busy_cyc++;
      if (done) done_cyc++;
      for (int r = 0; r < ROWS; r++) begin
        if (gate_pos[r] && !pp[r]) pos_cnt[r]++;
        if (gate_neg[r] && !pn[r]) neg_cnt[r]++;
        for (int c = 0; c < COLS; c++)
          if (g[r] && drain[c] && !pc[r*COLS+c]) coin_cnt[r*COLS+c]++;
      end
      for (int c = 0; c < COLS; c++)
        if (drain[c] && !pd[c]) drn_cnt[c]++;
      if (g[0]) gate_run++;
      else begin if (gate_run != 0 && gate_run != 4) bad_gate_run++; gate_run = 0; end
      if (drain[0]) drain_run++;
      else begin if (drain_run != 0 && drain_run != 2) bad_drain_run++; drain_run = 0; end
      if ((|drain) && (g != (pp | pn))) bad_nest++;
      for (int r = 0; r < ROWS; r++)
        for (int c = 0; c < COLS; c++)
          pc[r*COLS+c] = g[r] & drain[c];
    end
    pp = gate_pos; pn = gate_neg; pd = drain;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic set_row(input int r, input int v);
    row_prob[r*9 +: 9] = 9'(v);
  endtask

  task automatic set_col(input int c, input int v);
    col_prob[c*8 +: 8] = 8'(v);
  endtask

  task automatic run(input int len);
    clear_counts();
    @(negedge clk);
    len_in = 8'(len);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
    @(negedge clk);
  endtask

  function automatic int exp_cnt(input int m);
    return (m == 0) ? 0 : m - 1;
  endfunction

  task automatic t_reset();
    chk(busy == 1'b0, "R8 busy at reset", int'(busy), 0);
    chk(done == 1'b0, "R8 done at reset", int'(done), 0);
    chk((gate_pos | gate_neg) == '0, "R8 gates at reset", int'(|(gate_pos | gate_neg)), 0);
    chk(drain == '0, "R8 drain at reset", int'(|drain), 0);
  endtask

  task automatic t_full_cycle();
    int rv [8];
    int rm [8];
    int cv [5];
    rv = '{255, 0, 1, 2, 100, -128, -256, -1};
    rm = '{255, 0, 1, 2, 100, 128, 255, 1};
    cv = '{255, 0, 1, 128, 37};
    row_prob = '0; col_prob = '0;
    for (int r = 0; r < 8; r++) set_row(r, rv[r]);
    for (int c = 0; c < 5; c++) set_col(c, cv[c]);
    run(255);
    for (int r = 0; r < ROWS; r++) begin
      int m, e;
      m = (r < 8) ? rm[r] : 0;
      e = exp_cnt(m);
      if (r < 8 && rv[r] < 0) begin
        chk(neg_cnt[r] == e, $sformatf("R1 R4 row %0d neg count", r), neg_cnt[r], e);
        chk(pos_cnt[r] == 0, $sformatf("R4 row %0d pos count", r), pos_cnt[r], 0);
      end else begin
        chk(pos_cnt[r] == e, $sformatf("R1 R4 row %0d pos count", r), pos_cnt[r], e);
        chk(neg_cnt[r] == 0, $sformatf("R4 row %0d neg count", r), neg_cnt[r], 0);
      end
    end
    for (int c = 0; c < COLS; c++) begin
      int e;
      e = (c < 5) ? exp_cnt(cv[c]) : 0;
      chk(drn_cnt[c] == e, $sformatf("R2 col %0d drain count", c), drn_cnt[c], e);
    end
    chk(coin_cnt[0] == 253, "R3 cell(0,0) coincidences", coin_cnt[0], 253);
    for (int r = 0; r < ROWS; r++)
      chk(coin_cnt[r*COLS+1] == 0, $sformatf("R3 cell(%0d,1) coincidences", r), coin_cnt[r*COLS+1], 0);
    chk(coin_cnt[1*COLS+0] == 0, "R3 cell(1,0) coincidences", coin_cnt[COLS], 0);
    chk(coin_cnt[3] == 126 || coin_cnt[3] == 127, "R3 cell(0,3) coincidences", coin_cnt[3], 127);
    chk(coin_cnt[5*COLS] == 126 || coin_cnt[5*COLS] == 127, "R3 cell(5,0) coincidences",
        coin_cnt[5*COLS], 127);
    chk(busy_cyc == 255*5, "R5 busy cycles len 255", busy_cyc, 255*5);
    chk(done_cyc == 1, "R8 done cycles", done_cyc, 1);
    chk(bad_gate_run == 0, "R6 gate run width", bad_gate_run, 0);
    chk(bad_drain_run == 0, "R6 drain run width", bad_drain_run, 0);
    chk(bad_nest == 0, "R6 drain inside gate", bad_nest, 0);
    chk((gate_pos | gate_neg) == '0 && drain == '0, "R8 idle outputs after run",
        int'(|{gate_pos, gate_neg, drain}), 0);
  endtask

  task automatic t_len_one();
    row_prob = '0; col_prob = '0;
    for (int r = 0; r < ROWS; r++) set_row(r, 255);
    set_col(0, 255);
    run(1);
    chk(busy_cyc == 5, "R5 busy cycles len 1", busy_cyc, 5);
    chk(done_cyc == 1, "R8 done cycles len 1", done_cyc, 1);
    chk(pos_cnt[0] <= 1, "R5 len 1 single slot", pos_cnt[0], 1);
  endtask

  task automatic t_default_len();
    run(0);
    chk(busy_cyc == 50*5, "R5 default length busy cycles", busy_cyc, 250);
    chk(done_cyc == 1, "R8 done cycles default", done_cyc, 1);
  endtask

  task automatic t_busy_ignore();
    row_prob = '0; col_prob = '0;
    set_row(0, 255);
    set_col(0, 200);
    clear_counts();
    @(negedge clk);
    len_in = 8'd10; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (15) @(negedge clk);
    set_row(1, 255); set_row(0, 0); len_in = 8'd255; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
    @(negedge clk);
    chk(busy_cyc == 50, "R7 run length unchanged", busy_cyc, 50);
    chk(pos_cnt[1] == 0, "R7 row 1 vector not reloaded", pos_cnt[1], 0);
    chk(pos_cnt[0] >= 8, "R7 row 0 vector kept", pos_cnt[0], 9);
    chk(busy == 1'b0, "R7 idle after run", int'(busy), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    clear_counts();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    mon_en = 1'b1;
    t_full_cycle();
    t_len_one();
    t_default_len();
    t_busy_ignore();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule